// File: doc/BRIEF.md
# Counting-Ramp Converter Sequencer

This block sequences a counter-type analog-to-digital conversion. A host pulses a start request; the block zeroes an N-bit code register that feeds an external DAC, then advances that code by one on every clock. An external comparator reports when the DAC level has met or exceeded the sampled analog input. On that report the code stops moving, is copied into a result register, and an end-of-conversion level tells the host the value may be read.

Because the first code at or above the input is kept, the result rounds the input up to the next whole step. Two inputs that fall inside the same step give the same code. Conversion length follows the input level: a result of k takes k+1 clocks after the start is accepted. If the comparator never reports, the code stops at all ones and that value is reported as full scale.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, busy, eoc, dacCode and resultCode are all 0.
- R2: A startReq high at a clock edge while busy is 0 is accepted. After that edge busy is 1, eoc is 0 and dacCode is 0.
- R3: While busy is 1 and cmpAtOrAbove is 0 with dacCode below all ones, dacCode rises by exactly one at each clock edge.
- R4: When cmpAtOrAbove is 1 while busy, the next edge copies dacCode into resultCode, sets eoc to 1 and clears busy. A result of k therefore raises eoc k+1 clocks after the edge that accepted start.
- R5: The result is the smallest code whose DAC level (code × step) is at or above the input. An input of 150.125 steps gives 151. Inputs of 150.125 and 150.875 steps give the same code.
- R6: If the comparator stays low, conversion ends with dacCode at all ones. resultCode is then all ones, after 2^N clocks.
- R7: startReq while busy is 1 has no effect. The running conversion keeps its count, result and duration.
- R8: After completion, eoc stays 1 and resultCode and dacCode hold until the next start is accepted. That acceptance clears eoc. resultCode keeps the previous value until the new conversion completes.
- R9: busy and eoc are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request to begin a conversion, sampled at the clock edge |
| cmpAtOrAbove | input | 1 | Comparator: 1 when the DAC level is at or above the analog input |
| dacCode | output | CODE_W | Code driven to the external DAC |
| resultCode | output | CODE_W | Latched result of the last finished conversion |
| busy | output | 1 | High while a conversion is counting |
| eoc | output | 1 | End of conversion; a level cleared by the next accepted start |

## Verification
The hardest condition to reach from the ports is a comparator that never trips. This forces the count onto its all-ones stop. The bench reaches it by giving the analog model a level above full scale, so the stop happens after a full 256-clock ramp. A start request in the middle of a ramp is also hard to reach, because it must land while busy is high. The bench raises start for several cycles during a mid-scale conversion and confirms that the result and the clock count match an undisturbed run.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } convState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearCount;
    logic stepCount;
    logic captureResult;
  } rampStrobe_t;

endpackage

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
  import ramp_adc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        cmpAtOrAbove,
  input  logic        countAtTop,
  output rampStrobe_t strobe,
  output logic        busy,
  output logic        eoc
);

  convState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (startReq) begin
          strobe.clearCount = 1'b1;
          nextState         = ST_RUN;
        end
      end
      ST_RUN: begin
        // start is deliberately not looked at here
        if (cmpAtOrAbove || countAtTop) begin
          strobe.captureResult = 1'b1;
          nextState            = ST_DONE;
        end else begin
          strobe.stepCount = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_RUN);
  assign eoc  = (state == ST_DONE);

  // R9: the two status levels exclude each other
  a_r9_busy_eoc_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && eoc));

  // R7: a start during counting does not end or restart the run
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !cmpAtOrAbove && !countAtTop) |=> busy);

endmodule

// File: rtl/ramp_adc_dp.sv
module ramp_adc_dp
  import ramp_adc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampStrobe_t       strobe,
  output logic [CODE_W-1:0] countQ,
  output logic [CODE_W-1:0] resultQ,
  output logic              countAtTop
);

  localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] ONE_CODE = {{(CODE_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.clearCount) begin
      countQ <= '0;
    end else if (strobe.stepCount) begin
      countQ <= countQ + ONE_CODE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     resultQ <= '0;
    else if (strobe.captureResult) resultQ <= countQ;
  end

  assign countAtTop = (countQ == TOP_CODE);

  // R3: the sequencer never asks for a step past the top code
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepCount |-> !countAtTop);

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              cmpAtOrAbove,
  output logic [CODE_W-1:0] dacCode,
  output logic [CODE_W-1:0] resultCode,
  output logic              busy,
  output logic              eoc
);

  localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

  rampStrobe_t strobe;
  logic        countAtTop;

  ramp_adc_seq uSeq (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .cmpAtOrAbove (cmpAtOrAbove),
    .countAtTop   (countAtTop),
    .strobe       (strobe),
    .busy         (busy),
    .eoc          (eoc)
  );

  ramp_adc_dp #(.CODE_W(CODE_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .countQ     (dacCode),
    .resultQ    (resultCode),
    .countAtTop (countAtTop)
  );

  // R2: an accepted start zeroes the code and raises busy
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> (busy && !eoc && dacCode == '0));

  // R3: one step per clock while counting
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmpAtOrAbove && dacCode != TOP_CODE)
      |=> (busy && dacCode == $past(dacCode) + 1'b1));

  // R4: comparator trip freezes and reports the code
  a_r4_capture_on_trip: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmpAtOrAbove)
      |=> (eoc && !busy && resultCode == $past(dacCode) && $stable(dacCode)));

  // R6: the top code ends the run as full scale
  a_r6_full_scale_stop: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dacCode == TOP_CODE) |=> (eoc && resultCode == TOP_CODE));

  // R8: finished result and code hold while no start arrives
  a_r8_hold_after_done: assert property (@(posedge clk) disable iff (!rstN)
    (eoc && !startReq) |=> (eoc && $stable(resultCode) && $stable(dacCode)));

endmodule

// File: tb/tb_ramp_adc_ctrl.sv
module tb_ramp_adc_ctrl;

  localparam int CODE_W = 8;
  localparam int FRAC   = 8;   // analog level in eighths of a step

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic              cmpAtOrAbove;
  logic [CODE_W-1:0] dacCode, resultCode;
  logic              busy, eoc;
  int                vinEighths = 0;
  int                checks = 0;
  int                failures = 0;
  int                cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  // behavioural DAC and comparator
  assign cmpAtOrAbove = (int'(dacCode) * FRAC >= vinEighths);

  ramp_adc_ctrl #(.CODE_W(CODE_W)) dut (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .cmpAtOrAbove (cmpAtOrAbove),
    .dacCode      (dacCode),
    .resultCode   (resultCode),
    .busy         (busy),
    .eoc          (eoc)
  );

  // {input in eighths, expected code, expected clocks to eoc}
  localparam int NVEC = 8;
  localparam int VEC [NVEC][3] = '{
    '{0,    0,   1},    // zero input
    '{1020, 128, 129},  // mid-scale, 127.5 steps
    '{1201, 151, 152},  // 150.125 steps rounds up
    '{1207, 151, 152},  // same step, same code
    '{1209, 152, 153},  // just above step 151
    '{8,    1,   2},    // exactly one step
    '{2040, 255, 256},  // exactly full scale
    '{4000, 255, 256}   // above full scale, never trips
  };

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // start a conversion, optionally pulsing start mid-run; return clocks to eoc
  task automatic convert(input int vin, input int pokeAt, output int clocks, output int stepErr);
    vinEighths = vin;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check("R2", int'(busy), 1, "busy after start");
    check("R2", int'(dacCode), 0, "code after start");
    check("R2", int'(eoc), 0, "eoc after start");
    clocks = 0;
    stepErr = 0;
    while (clocks < 1000) begin
      startReq = (pokeAt >= 0 && clocks >= pokeAt && clocks < pokeAt + 4);
      @(negedge clk);
      clocks++;
      if (busy && eoc) stepErr++;               // R9
      if (eoc) break;
      if (int'(dacCode) != clocks) stepErr++;   // R3
    end
    startReq = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    int clocks, stepErr;
    logic [CODE_W-1:0] heldRes, heldCode;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(busy), 0, "busy in reset");
    check("R1", int'(eoc), 0, "eoc in reset");
    check("R1", int'(dacCode), 0, "code in reset");
    check("R1", int'(resultCode), 0, "result in reset");
    rstN = 1'b1;
    @(negedge clk);

    // vector walk: R4, R5, R6, R3, R9
    for (int i = 0; i < NVEC; i++) begin
      convert(VEC[i][0], -1, clocks, stepErr);
      check("R4", int'(eoc), 1, "eoc at end");
      check("R5", int'(resultCode), VEC[i][1], "result code");
      check("R4", clocks, VEC[i][2], "clocks to eoc");
      check("R3", stepErr, 0, "step or exclusivity errors");
      if (VEC[i][0] >= 2040) check("R6", int'(resultCode), 255, "full scale result");
    end

    // R7: start pulsed for several cycles during a mid-scale run
    convert(1020, 40, clocks, stepErr);
    check("R7", int'(resultCode), 128, "result with mid-run start");
    check("R7", clocks, 129, "clocks with mid-run start");
    check("R7", stepErr, 0, "count disturbed by mid-run start");

    // R8: hold while idle after completion, even if the input moves
    heldRes = resultCode;
    heldCode = dacCode;
    vinEighths = 16;
    repeat (20) @(negedge clk);
    check("R8", int'(eoc), 1, "eoc held");
    check("R8", int'(resultCode), int'(heldRes), "result held");
    check("R8", int'(dacCode), int'(heldCode), "code held");

    // R8: next start clears eoc, old result kept until new completion
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check("R8", int'(eoc), 0, "eoc cleared by start");
    check("R8", int'(resultCode), 128, "old result during run");
    @(negedge clk);
    check("R8", int'(resultCode), 128, "old result one clock later");
    repeat (3) @(negedge clk);
    check("R8", int'(resultCode), 2, "new result after completion");
    check("R9", int'(busy), 0, "busy low at end");

    finish_run();
  end

endmodule